// File: doc/BRIEF.md
# Serial Flag Offset Loader

This block owns the two threshold values that a FIFO's programmable flags compare against: the empty-side offset, which sets the almost-empty threshold, and the full-side offset, which sets the almost-full threshold. While master reset is held, every rising write-clock edge loads both offsets from one of eight preset pairs. Three configuration inputs choose the pair: the load strobe and a two-bit preset select.

After master reset, software or a board controller can replace both offsets one bit at a time. It does this by pulling the load strobe and the shift enable low together and presenting bits on the serial input, one per write-clock edge. A frame holds the empty offset followed by the full offset. Each offset is OFS_W = clog2(DEPTH) bits and is sent least significant bit first. Each offset becomes visible on its output as soon as its last bit is captured.

A partial reset of the FIFO leaves both offsets and the position inside a frame untouched. A master reset restores the presets and discards any partly shifted frame.

Top module: `serial_ofs_loader`

## Requirements
- R1: On every rising `wclk` edge with `master_rst_n` low, both offsets load the preset 2^(s+3)-1, where s is the 3-bit value {`load_strobe_n`, `preset_sel[1]`, `preset_sel[0]`} with `load_strobe_n` as the most significant bit. This gives 7 for s=0 and 1023 for s=7. The result is truncated to OFS_W bits.
- R2: Outputs change only on rising `wclk` edges. A new value is visible after the edge that produced it.
- R3: A serial bit is taken from `ser_in` on a rising edge only when `master_rst_n` is high and `load_strobe_n` and `shift_en_n` are both low. Exactly one bit is taken per such edge.
- R4: A frame is 2*OFS_W bits. The first OFS_W bits form the empty offset and the next OFS_W bits form the full offset, each least significant bit first.
- R5: `empty_offset` takes its new value on the edge that captures its final (OFS_W-th) bit, while `full_offset` keeps its old value. `full_offset` changes only on the edge that captures the frame's last bit.
- R6: After a complete frame the bit position returns to the start, so the next captured bit is bit 0 of the empty offset.
- R7: Releasing the strobes in the middle of a frame leaves both offsets and the captured partial bits unchanged. The next shift continues from the bit position where shifting stopped.
- R8: Edges where only one of `load_strobe_n` and `shift_en_n` is low capture nothing, change no offset and do not advance the bit position.
- R9: `part_rst_n` has no effect on the offsets or on the bit position.
- R10: Master reset in the middle of a frame discards the partial bits. The first serial bit after reset is bit 0 of the empty offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock; all state changes on its rising edge |
| master_rst_n | input | 1 | Master reset, active low, synchronous; loads presets |
| part_rst_n | input | 1 | FIFO partial reset, active low; ignored by this block |
| load_strobe_n | input | 1 | Preset MSB during master reset; serial strobe after it |
| shift_en_n | input | 1 | Serial shift enable, active low; must be high during master reset |
| preset_sel | input | 2 | Preset select, low two bits of the preset index |
| ser_in | input | 1 | Serial offset data, LSB first |
| empty_offset | output | OFS_W | Current almost-empty threshold |
| full_offset | output | OFS_W | Current almost-full threshold |

## Verification
A bit position that drifts or fails to wrap would not stay hidden. The first complete frame after the fault would show rotated or mixed bits on both offsets, at the edge carrying the last expected bit. A capture that leaks through a single strobe, a pause or a partial reset would show the same rotation, so each such stimulus is followed by a full frame of known values. A wrong preset decode shows directly on the outputs one edge into master reset. A word committed on the wrong edge shows as an offset changing one bit early or late.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    // Preset threshold for a 3-bit configuration index: 2^(idx+3) - 1
    function automatic logic [31:0] preset_ofs(input logic [2:0] idx);
        return (32'd1 << (32'(idx) + 32'd3)) - 32'd1;
    endfunction

endpackage

// File: rtl/ofs_frame_cnt.sv
module ofs_frame_cnt #(
    parameter int OFS_W = 10,
    localparam int POS_W = (OFS_W > 1) ? $clog2(OFS_W) : 1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             step,
    output logic [POS_W-1:0] pos,
    output logic             second,
    output logic             word_last,
    output logic             frame_last
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             second;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        word_last  = (st_q.pos == POS_W'(OFS_W - 1));
        frame_last = word_last && st_q.second;
        if (clr) begin
            st_d = '0;
        end else if (step) begin
            if (word_last) begin
                st_d.pos    = '0;
                st_d.second = !st_q.second;
            end else begin
                st_d.pos = st_q.pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pos    = st_q.pos;
    assign second = st_q.second;

    // R6
    frame_wrap_chk: assert property (@(posedge clk) disable iff (clr)
        (step && frame_last) |=> (pos == '0 && !second));

    // R4
    pos_range_chk: assert property (@(posedge clk) disable iff (clr)
        step |=> (pos <= POS_W'(OFS_W - 1)));

    // R7
    hold_pos_chk: assert property (@(posedge clk) disable iff (clr)
        !step |=> ($stable(pos) && $stable(second)));

endmodule

// File: rtl/ofs_assembler.sv
module ofs_assembler #(
    parameter int OFS_W = 10,
    localparam int POS_W = (OFS_W > 1) ? $clog2(OFS_W) : 1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             step,
    input  logic             bit_in,
    input  logic [POS_W-1:0] pos,
    output logic [OFS_W-1:0] word
);

    typedef struct packed {
        logic [OFS_W-1:0] bits;
    } asm_t;

    asm_t st_d, st_q;

    always_comb begin
        word = st_q.bits;
        for (int i = 0; i < OFS_W; i++) begin
            if (pos == POS_W'(i)) begin
                word[i] = bit_in;
            end
        end
        st_d = st_q;
        if (clr) begin
            st_d.bits = '0;
        end else if (step) begin
            st_d.bits = word;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R7
    partial_hold_chk: assert property (@(posedge clk) disable iff (clr)
        !step |=> $stable(st_q.bits));

endmodule

// File: rtl/serial_ofs_loader.sv
module serial_ofs_loader #(
    parameter int DEPTH = 1024,
    localparam int OFS_W = $clog2(DEPTH),
    localparam int POS_W = (OFS_W > 1) ? $clog2(OFS_W) : 1
) (
    input  logic             wclk,
    input  logic             master_rst_n,
    input  logic             part_rst_n,
    input  logic             load_strobe_n,
    input  logic             shift_en_n,
    input  logic [1:0]       preset_sel,
    input  logic             ser_in,
    output logic [OFS_W-1:0] empty_offset,
    output logic [OFS_W-1:0] full_offset
);

    typedef struct packed {
        logic [OFS_W-1:0] empty;
        logic [OFS_W-1:0] full;
    } ofs_t;

    ofs_t             st_d, st_q;
    logic             clr;
    logic             shift;
    logic [POS_W-1:0] pos;
    logic             second;
    logic             word_last;
    logic             frame_last;
    logic [OFS_W-1:0] word;
    logic [OFS_W-1:0] preset;

    assign clr    = !master_rst_n;
    assign shift  = master_rst_n && !load_strobe_n && !shift_en_n;
    assign preset = OFS_W'(ofs_pkg::preset_ofs({load_strobe_n, preset_sel}));

    ofs_frame_cnt #(.OFS_W(OFS_W)) i_cnt (
        .clk        (wclk),
        .clr        (clr),
        .step       (shift),
        .pos        (pos),
        .second     (second),
        .word_last  (word_last),
        .frame_last (frame_last)
    );

    ofs_assembler #(.OFS_W(OFS_W)) i_asm (
        .clk    (wclk),
        .clr    (clr),
        .step   (shift),
        .bit_in (ser_in),
        .pos    (pos),
        .word   (word)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.empty = preset;
            st_d.full  = preset;
        end else if (shift && word_last) begin
            if (!second) begin
                st_d.empty = word;
            end else begin
                st_d.full = word;
            end
        end
    end

    always_ff @(posedge wclk) begin
        st_q <= st_d;
    end

    assign empty_offset = st_q.empty;
    assign full_offset  = st_q.full;

    // R8
    no_strobe_hold_chk: assert property (@(posedge wclk) disable iff (!master_rst_n)
        (load_strobe_n || shift_en_n) |=> ($stable(empty_offset) && $stable(full_offset)));

    // R9
    part_rst_ignored_chk: assert property (@(posedge wclk) disable iff (!master_rst_n)
        (!part_rst_n && load_strobe_n) |=> ($stable(empty_offset) && $stable(full_offset)));

    // R5
    full_commit_chk: assert property (@(posedge wclk) disable iff (!master_rst_n)
        (shift && !frame_last) |=> $stable(full_offset));

    // R5
    empty_commit_chk: assert property (@(posedge wclk) disable iff (!master_rst_n)
        (shift && (second || !word_last)) |=> $stable(empty_offset));

endmodule

// File: tb/test_serial_ofs_loader.sv
module test_serial_ofs_loader;

    localparam int DEPTH = 1024;
    localparam int W     = $clog2(DEPTH);

    logic         wclk = 1'b0;
    logic         master_rst_n = 1'b0;
    logic         part_rst_n = 1'b1;
    logic         load_strobe_n = 1'b0;
    logic         shift_en_n = 1'b1;
    logic [1:0]   preset_sel = 2'b00;
    logic         ser_in = 1'b0;
    logic [W-1:0] empty_offset;
    logic [W-1:0] full_offset;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 wclk = ~wclk;

    serial_ofs_loader #(.DEPTH(DEPTH)) i_serial_ofs_loader (
        .wclk          (wclk),
        .master_rst_n  (master_rst_n),
        .part_rst_n    (part_rst_n),
        .load_strobe_n (load_strobe_n),
        .shift_en_n    (shift_en_n),
        .preset_sel    (preset_sel),
        .ser_in        (ser_in),
        .empty_offset  (empty_offset),
        .full_offset   (full_offset)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] preset_val(input int s);
        return W'((1 << (s + 3)) - 1);
    endfunction

    // All tasks start and end just after a falling edge.
    task automatic shift_bit(input logic b);
        load_strobe_n = 1'b0;
        shift_en_n    = 1'b0;
        ser_in        = b;
        @(negedge wclk);
    endtask

    task automatic idle(input int k);
        load_strobe_n = 1'b1;
        shift_en_n    = 1'b1;
        repeat (k) @(negedge wclk);
    endtask

    task automatic shift_range(input logic [W-1:0] v, input int lo, input int hi);
        for (int i = lo; i < hi; i++) shift_bit(v[i]);
    endtask

    task automatic do_mrs(input int s);
        master_rst_n  = 1'b0;
        load_strobe_n = s[2];
        preset_sel    = s[1:0];
        shift_en_n    = 1'b1;
        ser_in        = 1'b0;
        repeat (2) @(negedge wclk);
        master_rst_n  = 1'b1;
        load_strobe_n = 1'b1;
        @(negedge wclk);
    endtask

    task automatic t_presets();
        for (int s = 0; s < 8; s++) begin
            do_mrs(s);
            chk("R1 empty preset", empty_offset, preset_val(s));
            chk("R1 full preset", full_offset, preset_val(s));
        end
    endtask

    task automatic t_frame();
        logic [W-1:0] n = 10'h2A5;
        logic [W-1:0] m = 10'h15A;
        do_mrs(1);
        shift_range(n, 0, W - 1);
        chk("R5 empty before last bit", empty_offset, preset_val(1));
        shift_bit(n[W-1]);
        chk("R5 empty after last bit", empty_offset, n);
        chk("R5 full unchanged mid frame", full_offset, preset_val(1));
        shift_range(m, 0, W - 1);
        chk("R5 full before last bit", full_offset, preset_val(1));
        shift_bit(m[W-1]);
        chk("R4 full after frame", full_offset, m);
        chk("R4 empty after frame", empty_offset, n);
        shift_range(10'd3, 0, W);
        shift_range(10'd1000, 0, W);
        idle(1);
        chk("R6 second frame empty", empty_offset, 10'd3);
        chk("R6 second frame full", full_offset, 10'd1000);
    endtask

    task automatic t_pause();
        logic [W-1:0] n = 10'h0F3;
        logic [W-1:0] m = 10'h30C;
        shift_range(n, 0, 4);
        load_strobe_n = 1'b1; shift_en_n = 1'b1;
        for (int i = 0; i < 3; i++) begin ser_in = i[0]; @(negedge wclk); end
        chk("R7 empty held in pause", empty_offset, 10'd3);
        chk("R7 full held in pause", full_offset, 10'd1000);
        shift_range(n, 4, W);
        chk("R7 resumed empty", empty_offset, n);
        shift_range(m, 0, 7);
        idle(2);
        shift_range(m, 7, W);
        idle(1);
        chk("R7 resumed full", full_offset, m);
    endtask

    task automatic t_single_strobe();
        logic [W-1:0] n = 10'h111;
        logic [W-1:0] m = 10'h222;
        for (int i = 0; i < 5; i++) begin
            load_strobe_n = 1'b0; shift_en_n = 1'b1; ser_in = ~i[0]; @(negedge wclk);
        end
        for (int i = 0; i < 5; i++) begin
            load_strobe_n = 1'b1; shift_en_n = 1'b0; ser_in = i[0]; @(negedge wclk);
        end
        chk("R8 empty untouched", empty_offset, 10'h0F3);
        chk("R8 full untouched", full_offset, 10'h30C);
        shift_range(n, 0, W);
        shift_range(m, 0, W);
        idle(1);
        chk("R3 aligned empty", empty_offset, n);
        chk("R3 aligned full", full_offset, m);
    endtask

    task automatic t_part_reset();
        logic [W-1:0] n = 10'h055;
        logic [W-1:0] m = 10'h3AA;
        shift_range(n, 0, 3);
        load_strobe_n = 1'b1; shift_en_n = 1'b1;
        part_rst_n = 1'b0;
        repeat (2) @(negedge wclk);
        part_rst_n = 1'b1;
        chk("R9 empty after partial reset", empty_offset, 10'h111);
        chk("R9 full after partial reset", full_offset, 10'h222);
        shift_range(n, 3, W);
        shift_range(m, 0, W);
        idle(1);
        chk("R9 continued empty", empty_offset, n);
        chk("R9 continued full", full_offset, m);
    endtask

    task automatic t_mrs_mid();
        logic [W-1:0] n = 10'h1C7;
        logic [W-1:0] m = 10'h238;
        shift_range(n, 0, 5);
        do_mrs(2);
        chk("R10 preset after reset", empty_offset, preset_val(2));
        chk("R2 full preset after reset", full_offset, preset_val(2));
        shift_range(n, 0, W);
        shift_range(m, 0, W);
        idle(1);
        chk("R10 restart empty", empty_offset, n);
        chk("R10 restart full", full_offset, m);
    endtask

    initial begin
        @(negedge wclk);
        @(negedge wclk);
        chk("R1 reset state empty", empty_offset, preset_val(0));
        chk("R1 reset state full", full_offset, preset_val(0));
        t_presets();
        t_frame();
        t_pause();
        t_single_strobe();
        t_part_reset();
        t_mrs_mid();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge wclk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule